// File: doc/BRIEF.md
# Byte-Lane Draining Output FIFO

This block is the read side of a result queue whose entries are 64 bits wide. A host reads the entry at the head of the queue in pieces: one byte, one 4-byte word, or the whole 8-byte dword at a time. The block keeps a record of which of the eight byte lanes of the head entry have already been handed out. When the last of the eight lanes has been read, the head entry is removed and the next stored entry, if there is one, becomes readable. A single read may take several cycles' worth of mixed widths to drain an entry, for example one word followed by four bytes.

Two problems are reported through sticky status flags. The address-error flag is raised by a read that touches a lane already read from the current head, by a misaligned word or dword read, or by the reserved size code. The underflow flag is raised by a read while the queue is empty. A read that raises either flag returns zero and leaves the lane record untouched. Each flag stays set until the host clears it. A simple push port stands in for the producer, and the number of stored entries is visible as a level count.

Top module: `dword_drain_fifo`

## Requirements
- R1: After reset, `level` is 0, `full` is 0, both error flags are 0 and `rd_data` is 0.
- R2: A cycle with `push_valid` high while `level` is below DEPTH stores `push_data` at the tail and raises `level` by one; while `level` equals DEPTH (`full` high) the push is dropped and stored contents and `level` are unchanged.
- R3: A read with `rd_size` = 0 (byte) at `rd_addr` = a, on a non-empty queue and an unread lane a, returns byte lane a of the head entry on `rd_data[8a+7:8a]` in the cycle after `rd_en`, with every other bit zero.
- R4: A read with `rd_size` = 1 (word) at address 0 or 4 returns lanes 0-3 or lanes 4-7 of the head in their own bit positions; `rd_size` = 2 (dword) at address 0 returns all eight lanes; unread bits are zero.
- R5: The read that completes the eighth lane of the head removes it: `level` drops by one (unless a push is accepted in the same cycle), the lane record is cleared, and the next entry in push order becomes the head.
- R6: A read whose lanes include any lane already read from the current head sets the address-error flag, returns zero, and neither marks lanes nor dequeues.
- R7: A word read with `rd_addr[1:0]` not zero, a dword read with `rd_addr` not zero, or any read with `rd_size` = 3 sets the address-error flag, returns zero and leaves the lane record unchanged.
- R8: A read while `level` is 0 returns zero and sets the underflow flag.
- R9: Both flags are sticky; `stat_clr[0]` clears the address-error flag and `stat_clr[1]` clears the underflow flag, and a new error in the same cycle as its clear leaves the flag set.
- R10: `level` always equals the number of stored entries, never exceeds DEPTH, and is unchanged in any cycle with neither a push nor a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Producer offers an entry this cycle |
| push_data | input | 64 | Entry to store |
| rd_en | input | 1 | Host read strobe, one read per cycle |
| rd_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| rd_addr | input | 3 | Byte offset within the head entry |
| stat_clr | input | 2 | Clear strobes: bit 0 address error, bit 1 underflow |
| rd_data | output | 64 | Read result in lane positions, valid the cycle after `rd_en` |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| full | output | 1 | Queue holds DEPTH entries |
| err_addr | output | 1 | Sticky address-error flag |
| err_underflow | output | 1 | Sticky underflow flag |

## Verification
The properties assume that the host presents at most one read per cycle and that `rd_size` and `rd_addr` are meaningful only while `rd_en` is high; they make no assumption about the order of reads within an entry. The level properties assume a push is a single-cycle strobe that the producer does not expect to be retried when dropped. The stimulus drives every input on the falling edge, holds each strobe for exactly one cycle, and sweeps every size code against every address, including reserved and misaligned ones, while refilling the queue so that both empty and partly drained heads are exercised.

// File: rtl/dwd_pkg.sv
// Package: shared constants and the read-size encoding of the draining FIFO.
// Assumes a 64-bit entry made of eight byte lanes.
package dwd_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 8;
    localparam int ENTRY_W = LANE_W * LANES;
    localparam int ADDR_W  = $clog2(LANES);
    localparam int HALF    = LANES / 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } rd_size_e;
endpackage

// File: rtl/dwd_lane_decode.sv
// Module: turns a read size and byte offset into the set of lanes it covers
// and an alignment verdict. Purely combinational. Assumes word = half entry.
module dwd_lane_decode
    import dwd_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  lane_mask,
    output logic              aligned
);
    rd_size_e sz;
    assign sz = rd_size_e'(size);

    // Alignment rule per size code; the reserved code is never aligned.
    always_comb begin
        unique case (sz)
            SZ_BYTE:  aligned = 1'b1;
            SZ_WORD:  aligned = (addr[ADDR_W-2:0] == '0);
            SZ_DWORD: aligned = (addr == '0);
            default:  aligned = 1'b0;
        endcase
    end

    // One select term per lane, built by generate.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_IDX = ADDR_W'(i);
        localparam logic              UPPER    = (i >= HALF);
        logic hit_byte, hit_word, hit_dword;
        assign hit_byte  = (sz == SZ_BYTE)  && (addr == LANE_IDX);
        assign hit_word  = (sz == SZ_WORD)  && (addr[ADDR_W-1] == UPPER);
        assign hit_dword = (sz == SZ_DWORD);
        assign lane_mask[i] = hit_byte | hit_word | hit_dword;
    end
endmodule

// File: rtl/dwd_store.sv
// Module: ring-buffer storage for DEPTH entries with a level counter.
// Pushes while full are dropped. Assumes pop is only asserted when not empty.
module dwd_store
    import dwd_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head_data,
    output logic [CNTW-1:0]    count,
    output logic               empty,
    output logic               full
);
    localparam logic [PTRW-1:0] LAST_PTR = PTRW'(DEPTH - 1);
    localparam logic [CNTW-1:0] CAP      = CNTW'(DEPTH);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PTRW-1:0]    wr_ptr, rd_ptr;
    logic               accept;

    assign full      = (count == CAP);
    assign empty     = (count == '0);
    assign accept    = push && !full;
    assign head_data = mem[rd_ptr];

    // Write the accepted entry into the tail slot.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    // Advance the tail pointer on every accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_ptr <= '0;
        else if (accept) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the head pointer on every dequeue.
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_ptr <= '0;
        else if (pop) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    end

    // Track the number of stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dwd_lane_track.sv
// Module: keeps the record of lanes already read from the head entry,
// grants or refuses each read, and requests a dequeue on the last lane.
// Assumes at most one read per cycle.
module dwd_lane_track
    import dwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             empty,
    input  logic [LANES-1:0] lane_mask,
    input  logic             aligned,
    output logic             grant,
    output logic             pop,
    output logic             addr_err,
    output logic             under_err
);
    logic [LANES-1:0] done_lanes;
    logic [LANES-1:0] next_lanes;
    logic             overlap;

    assign overlap    = |(lane_mask & done_lanes);
    assign under_err  = rd_en && empty;
    assign addr_err   = rd_en && !empty && (!aligned || overlap);
    assign grant      = rd_en && !empty && aligned && !overlap;
    assign next_lanes = done_lanes | lane_mask;
    assign pop        = grant && (&next_lanes);

    // Mark granted lanes; wipe the record when the head leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)     done_lanes <= '0;
        else if (pop)   done_lanes <= '0;
        else if (grant) done_lanes <= next_lanes;
    end
endmodule

// File: rtl/dword_drain_fifo.sv
// Module: top of the byte-lane draining output FIFO. Holds DEPTH 64-bit
// entries, lets the host drain the head by byte, word or dword, dequeues
// once every lane has been read, and keeps sticky error flags.
// Assumes DEPTH >= 2 and one host read per cycle.
module dword_drain_fifo
    import dwd_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_valid,
    input  logic [ENTRY_W-1:0]    push_data,
    input  logic                  rd_en,
    input  logic [1:0]            rd_size,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [1:0]            stat_clr,
    output logic [ENTRY_W-1:0]    rd_data,
    output logic [CNTW-1:0]       level,
    output logic                  full,
    output logic                  err_addr,
    output logic                  err_underflow
);
    logic [ENTRY_W-1:0] head_data;
    logic [ENTRY_W-1:0] bit_mask;
    logic [LANES-1:0]   lane_mask;
    logic               aligned, empty, grant, pop, addr_set, under_set;

    dwd_lane_decode u_decode (
        .size      (rd_size),
        .addr      (rd_addr),
        .lane_mask (lane_mask),
        .aligned   (aligned)
    );

    dwd_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (pop),
        .head_data (head_data),
        .count     (level),
        .empty     (empty),
        .full      (full)
    );

    dwd_lane_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .empty     (empty),
        .lane_mask (lane_mask),
        .aligned   (aligned),
        .grant     (grant),
        .pop       (pop),
        .addr_err  (addr_set),
        .under_err (under_set)
    );

    // Widen the lane selection to one bit per data bit.
    for (genvar i = 0; i < LANES; i++) begin : g_expand
        assign bit_mask[i*LANE_W +: LANE_W] = {LANE_W{lane_mask[i]}};
    end

    // Register the read result; refused reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= grant ? (head_data & bit_mask) : '0;
    end

    // Sticky address-error flag; a new error beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_addr <= 1'b0;
        else        err_addr <= addr_set | (err_addr & ~stat_clr[0]);
    end

    // Sticky underflow flag; a new error beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_underflow <= 1'b0;
        else        err_underflow <= under_set | (err_underflow & ~stat_clr[1]);
    end
endmodule

// File: rtl/dwd_checker.sv
// Checker: port-level properties of dword_drain_fifo, attached by bind.
module dwd_checker
    import dwd_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               push_valid,
    input logic               rd_en,
    input logic [1:0]         rd_size,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [1:0]         stat_clr,
    input logic [ENTRY_W-1:0] rd_data,
    input logic [CNTW-1:0]    level,
    input logic               full,
    input logic               err_addr,
    input logic               err_underflow
);
    localparam logic [CNTW-1:0] CAP = CNTW'(DEPTH);

    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && level == '0 |=> err_underflow && rd_data == '0);

    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CAP);

    a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !push_valid |=> $stable(level));

    a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        full && push_valid && !rd_en |=> level == CAP);

    a_r7_misaligned_word: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && level != '0 && rd_size == 2'd1 && rd_addr[1:0] != 2'd0
        |=> err_addr && rd_data == '0);

    a_r7_reserved_size: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && level != '0 && rd_size == 2'd3 |=> err_addr && rd_data == '0);

    a_r9_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_addr && !stat_clr[0] |=> err_addr);

    a_r9_under_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow && !stat_clr[1] |=> err_underflow);
endmodule

bind dword_drain_fifo dwd_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/dword_drain_fifo_bench.sv
// Bench: sweeps every size/offset pair against a queue kept partly filled,
// predicting each result from a model written from the requirements.
module dword_drain_fifo_bench;
    localparam int DEPTH = 4;
    localparam int CNTW  = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push_valid = 1'b0;
    logic [63:0]     push_data = '0;
    logic            rd_en = 1'b0;
    logic [1:0]      rd_size = '0;
    logic [2:0]      rd_addr = '0;
    logic [1:0]      stat_clr = '0;
    logic [63:0]     rd_data;
    logic [CNTW-1:0] level;
    logic            full, err_addr, err_underflow;

    int checks = 0, failures = 0, next_k = 0;
    bit finished = 0;

    // Model state derived from the requirements.
    logic [63:0] mq [DEPTH];
    int          mh = 0, mc = 0;
    logic [7:0]  mbm = '0;
    bit          mea = 0, meu = 0;

    always #2 clk = ~clk;

    dword_drain_fifo #(.DEPTH(DEPTH)) u_dword_drain_fifo (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .rd_en(rd_en), .rd_size(rd_size), .rd_addr(rd_addr), .stat_clr(stat_clr),
        .rd_data(rd_data), .level(level), .full(full),
        .err_addr(err_addr), .err_underflow(err_underflow)
    );

    function automatic logic [63:0] ent(int k);
        logic [63:0] r;
        for (int l = 0; l < 8; l++) r[l*8 +: 8] = 8'((k * 16 + l) & 8'hff);
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_flags(string req);
        chk(req, {62'd0, err_underflow, err_addr}, {62'd0, meu, mea});
    endtask

    task automatic push(int k);
        @(negedge clk);
        push_valid = 1'b1; push_data = ent(k);
        @(negedge clk);
        push_valid = 1'b0;
        if (mc < DEPTH) begin
            mq[(mh + mc) % DEPTH] = ent(k);
            mc++;
        end
        chk("R2 level", 64'(level), 64'(mc));
        chk("R2 full", 64'(full), 64'(mc == DEPTH));
    endtask

    task automatic rd(int sz, int ad, logic [1:0] clr);
        logic [7:0]  m;
        bit          ok;
        logic [63:0] exp;
        string       tag;
        @(negedge clk);
        rd_en = 1'b1; rd_size = 2'(sz); rd_addr = 3'(ad); stat_clr = clr;
        @(negedge clk);
        rd_en = 1'b0; stat_clr = '0;
        if (clr[0]) mea = 0;
        if (clr[1]) meu = 0;
        case (sz)
            0: begin m = 8'(1 << ad); ok = 1; end
            1: begin ok = (ad % 4 == 0); m = (ad < 4) ? 8'h0f : 8'hf0; end
            2: begin ok = (ad == 0); m = 8'hff; end
            default: begin ok = 0; m = 8'h00; end
        endcase
        exp = '0;
        if (mc == 0) begin
            tag = "R8"; meu = 1;
        end else if (!ok) begin
            tag = "R7"; mea = 1;
        end else if ((m & mbm) != 0) begin
            tag = "R6"; mea = 1;
        end else begin
            tag = (sz == 0) ? "R3" : "R4";
            for (int l = 0; l < 8; l++)
                if (m[l]) exp[l*8 +: 8] = mq[mh][l*8 +: 8];
            mbm = mbm | m;
            if (mbm == 8'hff) begin
                mbm = '0; mh = (mh + 1) % DEPTH; mc--;
                tag = "R5";
            end
        end
        chk({tag, " data"}, rd_data, exp);
        chk({tag, " flags"}, {62'd0, err_underflow, err_addr}, {62'd0, meu, mea});
        chk("R10 level", 64'(level), 64'(mc));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 data", rd_data, '0);
        chk("R1 level", 64'(level), 0);
        chk("R1 full", 64'(full), 0);
        chk_flags("R1");

        // R8 empty read, then R9 clear
        rd(0, 0, 2'b00);
        rd(0, 0, 2'b10);          // new underflow beats clear: stays set (R9)
        chk_flags("R9 set wins");
        @(negedge clk); stat_clr = 2'b11;
        @(negedge clk); stat_clr = 2'b00; mea = 0; meu = 0;
        chk_flags("R9 cleared");

        // R2 fill past capacity; the extra entry is dropped
        for (int k = 0; k < DEPTH + 1; k++) push(next_k++);

        // Entry 0: scattered bytes with a repeated lane (R3, R6)
        rd(0, 7, 2'b00); rd(0, 0, 2'b00); rd(0, 3, 2'b00);
        rd(0, 3, 2'b00);          // R6 repeat
        rd(1, 0, 2'b00);          // R6 word overlaps lane 0/3
        rd(0, 1, 2'b00); rd(0, 2, 2'b00); rd(0, 6, 2'b00);
        rd(0, 4, 2'b00); rd(0, 5, 2'b00);   // R5 pop
        @(negedge clk); stat_clr = 2'b01;
        @(negedge clk); stat_clr = 2'b00; mea = 0;
        chk_flags("R9 addr clear");

        // Entry 1: upper word then lower word (R4, R5)
        rd(1, 4, 2'b00); rd(1, 0, 2'b00);
        // Entry 2: whole dword
        rd(2, 0, 2'b00);
        // Entry 3: word then bytes; dropped entry 4 must not follow (R2)
        rd(1, 0, 2'b00); rd(0, 4, 2'b00); rd(0, 5, 2'b00); rd(0, 6, 2'b00); rd(0, 7, 2'b00);
        rd(2, 0, 2'b00);          // R8 now empty
        @(negedge clk); stat_clr = 2'b11;
        @(negedge clk); stat_clr = 2'b00; mea = 0; meu = 0;

        // Exhaustive sweep of every size/offset pair, refilling as needed
        for (int pass = 0; pass < 3; pass++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int ad = 0; ad < 8; ad++) begin
                    if (pass < 2 && mc < 2) push(next_k++);
                    rd(sz, ad, 2'(pass == 1 ? 2'b11 : 2'b00));
                end
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule